// File: doc/BRIEF.md
# Lockable Sensor Configuration Register

This block is the 16-bit configuration register of a temperature-monitor slave. A bus front end, outside this block, presents a write strobe and a 16-bit data word; the register applies per-bit write protection and drives every field as a separate output to the event and measurement logic. The read value is formed combinationally from the stored fields, a live event-status input and constant zeros.

Two sticky lock bits protect the alarm and critical limit registers held elsewhere, and they also freeze parts of this register. Once set, a lock bit can only be cleared by power-on reset. While either lock is set, the hysteresis code, event output enable, output polarity and mode bit keep their values. Shutdown can still be cleared but not set. The critical-only select cannot be set while the alarm lock is held. Every write is checked against the lock state from before the write, so a write that sets a lock still lands its other fields. Writing 1 to the event-clear position gives a one-cycle pulse, and that position always reads back as 0.

Top module: `thermCfgReg`

## Requirements
- R1: After power-on reset (porN low, asynchronous), every stored field is 0, so rdData reads 0x0000 apart from bit 4, which follows eventActive.
- R2: rdData bits 15:11 always read 0, and writing ones to them changes no output.
- R3: With both lock bits 0, a write loads bits 10:9 into hystSel (code 00 off, 01 1.5 °C, 10 3 °C, 11 6 °C), bit 3 into eventEnable, bit 1 into eventPolarity and bit 0 into intMode. Each value reads back at the same position, and the output changes on the clock edge that samples wrEn.
- R4: Writing 1 to bit 7 sets critLock and writing 1 to bit 6 sets alarmLock. Writing 0 to either leaves it unchanged, and only porN clears them.
- R5: While critLock or alarmLock is 1, writes leave bits 10:9, 3, 1 and 0 unchanged in both directions.
- R6: Bit 8 (shutdown) is set by a write of 1 only while both lock bits are 0, and is cleared by a write of 0 at any time.
- R7: Bit 2 (critOnly) is set by a write of 1 only while alarmLock is 0, and is cleared by a write of 0 at any time. critLock alone does not block it.
- R8: A write with bit 5 set drives clearEvent high for exactly the cycle after the write edge. Bit 5 of rdData always reads 0.
- R9: Bit 4 of rdData shows the eventActive input, and writes to bit 4 have no effect.
- R10: Lock protection uses the lock values held before the write, so one write that sets a lock bit also applies its other fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| wrEn | input | 1 | Write strobe, one write per cycle it is high |
| wrData | input | 16 | Write data |
| eventActive | input | 1 | Current event output state from the event logic, polarity independent |
| rdData | output | 16 | Register read value |
| hystSel | output | 2 | Hysteresis code |
| shutdown | output | 1 | Sensor shutdown request |
| critLock | output | 1 | Critical limit lock |
| alarmLock | output | 1 | Alarm limit lock |
| eventEnable | output | 1 | Event output enable |
| critOnly | output | 1 | Event triggered by critical crossing only |
| eventPolarity | output | 1 | Event output polarity, 1 active high |
| intMode | output | 1 | 1 interrupt mode, 0 comparator mode |
| clearEvent | output | 1 | One-cycle event-clear pulse |

## Verification
The assertions assume that porN is held low before the first clock edge and that wrEn and wrData are settled and known at every rising edge. They also assume that eventActive only affects the read value and never the stored fields. The bench drives every input on the falling edge and opens with porN low. It returns to power-on reset at regular points in the random run, so both locked and unlocked states are visited many times. Lock bits are set in only a small share of the random writes, so that the unlocked write paths also get long runs.

// File: rtl/thermcfg_pkg.sv
package thermcfg_pkg;
  localparam int CFG_W          = 16;
  localparam int HYST_W         = 2;
  localparam int POS_HYST_LO    = 9;
  localparam int POS_SHDN       = 8;
  localparam int POS_CRIT_LOCK  = 7;
  localparam int POS_ALARM_LOCK = 6;
  localparam int POS_CLR        = 5;
  localparam int POS_STATUS     = 4;
  localparam int POS_EV_EN      = 3;
  localparam int POS_CRIT_ONLY  = 2;
  localparam int POS_POL        = 1;
  localparam int POS_MODE       = 0;
  localparam int POS_HYST_HI    = POS_HYST_LO + HYST_W - 1;

  // Strobes from the write-rule control to the storage datapath.
  typedef struct packed {
    logic wrOpen;       // unlocked: load hysteresis, enable, polarity, mode
    logic shdnSet;
    logic shdnClr;
    logic critOnlySet;
    logic critOnlyClr;
    logic critLockSet;
    logic alarmLockSet;
    logic clrEvent;
  } cfgStrobe_t;
endpackage

// File: rtl/thermCfgCtrl.sv
module thermCfgCtrl
  import thermcfg_pkg::*;
#(
  parameter int DATA_W = CFG_W
) (
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              critLock,
  input  logic              alarmLock,
  output cfgStrobe_t        strb
);
  logic anyLock;
  logic unusedCtrl;

  assign anyLock    = critLock | alarmLock;
  assign unusedCtrl = ^{wrData[DATA_W-1:POS_SHDN+1], wrData[POS_STATUS:POS_EV_EN],
                        wrData[POS_POL:POS_MODE]};

  always_comb begin
    strb              = '0;
    strb.wrOpen       = wrEn && !anyLock;
    strb.shdnSet      = wrEn && wrData[POS_SHDN] && !anyLock;
    strb.shdnClr      = wrEn && !wrData[POS_SHDN];
    strb.critOnlySet  = wrEn && wrData[POS_CRIT_ONLY] && !alarmLock;
    strb.critOnlyClr  = wrEn && !wrData[POS_CRIT_ONLY];
    strb.critLockSet  = wrEn && wrData[POS_CRIT_LOCK];
    strb.alarmLockSet = wrEn && wrData[POS_ALARM_LOCK];
    strb.clrEvent     = wrEn && wrData[POS_CLR];
  end
endmodule

// File: rtl/thermCfgData.sv
module thermCfgData
  import thermcfg_pkg::*;
#(
  parameter int DATA_W = CFG_W,
  parameter int HW     = HYST_W
) (
  input  logic              clk,
  input  logic              porN,
  input  cfgStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              eventActive,
  output logic [DATA_W-1:0] rdData,
  output logic [HW-1:0]     hystSel,
  output logic              shutdown,
  output logic              critLock,
  output logic              alarmLock,
  output logic              eventEnable,
  output logic              critOnly,
  output logic              eventPolarity,
  output logic              intMode,
  output logic              clearEvent
);
  localparam int RSV_W = DATA_W - (POS_HYST_LO + HW);

  logic anyLock;
  logic unusedData;

  assign anyLock    = critLock | alarmLock;
  assign unusedData = ^{wrData[DATA_W-1:POS_HYST_LO+HW], wrData[POS_SHDN:POS_STATUS],
                        wrData[POS_CRIT_ONLY]};

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      hystSel       <= '0;
      shutdown      <= 1'b0;
      critLock      <= 1'b0;
      alarmLock     <= 1'b0;
      eventEnable   <= 1'b0;
      critOnly      <= 1'b0;
      eventPolarity <= 1'b0;
      intMode       <= 1'b0;
      clearEvent    <= 1'b0;
    end else begin
      if (strb.wrOpen) begin
        hystSel       <= wrData[POS_HYST_LO +: HW];
        eventEnable   <= wrData[POS_EV_EN];
        eventPolarity <= wrData[POS_POL];
        intMode       <= wrData[POS_MODE];
      end
      if (strb.shdnSet)           shutdown  <= 1'b1;
      else if (strb.shdnClr)      shutdown  <= 1'b0;
      if (strb.critOnlySet)       critOnly  <= 1'b1;
      else if (strb.critOnlyClr)  critOnly  <= 1'b0;
      if (strb.critLockSet)       critLock  <= 1'b1;
      if (strb.alarmLockSet)      alarmLock <= 1'b1;
      clearEvent <= strb.clrEvent;
    end
  end

  always_comb begin
    rdData                          = '0;
    rdData[POS_HYST_LO +: HW]       = hystSel;
    rdData[POS_SHDN]                = shutdown;
    rdData[POS_CRIT_LOCK]           = critLock;
    rdData[POS_ALARM_LOCK]          = alarmLock;
    rdData[POS_STATUS]              = eventActive;
    rdData[POS_EV_EN]               = eventEnable;
    rdData[POS_CRIT_ONLY]           = critOnly;
    rdData[POS_POL]                 = eventPolarity;
    rdData[POS_MODE]                = intMode;
    rdData[DATA_W-1 -: RSV_W]       = '0;
  end

  // R4: locks are sticky until power-on reset
  assert_crit_lock_sticky_R4: assert property (@(posedge clk) disable iff (!porN)
    critLock |=> critLock);
  assert_alarm_lock_sticky_R4: assert property (@(posedge clk) disable iff (!porN)
    alarmLock |=> alarmLock);
  // R5: protected fields frozen while any lock is held
  assert_locked_fields_stable_R5: assert property (@(posedge clk) disable iff (!porN)
    anyLock |=> ($stable(hystSel) && $stable(eventEnable) &&
                 $stable(eventPolarity) && $stable(intMode)));
  // R6: shutdown cannot rise while locked
  assert_no_shdn_set_locked_R6: assert property (@(posedge clk) disable iff (!porN)
    (anyLock && !shutdown) |=> !shutdown);
  // R7: critical-only cannot rise under the alarm lock
  assert_no_critonly_set_R7: assert property (@(posedge clk) disable iff (!porN)
    (alarmLock && !critOnly) |=> !critOnly);
endmodule

// File: rtl/thermCfgReg.sv
module thermCfgReg
  import thermcfg_pkg::*;
#(
  parameter int DATA_W = CFG_W,
  parameter int HW     = HYST_W
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              eventActive,
  output logic [DATA_W-1:0] rdData,
  output logic [HW-1:0]     hystSel,
  output logic              shutdown,
  output logic              critLock,
  output logic              alarmLock,
  output logic              eventEnable,
  output logic              critOnly,
  output logic              eventPolarity,
  output logic              intMode,
  output logic              clearEvent
);
  cfgStrobe_t strb;

  thermCfgCtrl #(.DATA_W(DATA_W)) u_ctrl (
    .wrEn      (wrEn),
    .wrData    (wrData),
    .critLock  (critLock),
    .alarmLock (alarmLock),
    .strb      (strb)
  );

  thermCfgData #(.DATA_W(DATA_W), .HW(HW)) u_data (
    .clk           (clk),
    .porN          (porN),
    .strb          (strb),
    .wrData        (wrData),
    .eventActive   (eventActive),
    .rdData        (rdData),
    .hystSel       (hystSel),
    .shutdown      (shutdown),
    .critLock      (critLock),
    .alarmLock     (alarmLock),
    .eventEnable   (eventEnable),
    .critOnly      (critOnly),
    .eventPolarity (eventPolarity),
    .intMode       (intMode),
    .clearEvent    (clearEvent)
  );

  // R8: clear pulse follows a write of 1 to the clear position, for one cycle only
  assert_clear_pulse_R8: assert property (@(posedge clk) disable iff (!porN)
    (wrEn && wrData[POS_CLR]) |=> clearEvent);
  assert_clear_single_R8: assert property (@(posedge clk) disable iff (!porN)
    !(wrEn && wrData[POS_CLR]) |=> !clearEvent);
endmodule

// File: tb/thermCfgReg_tb.sv
`timescale 1ns/1ps
module thermCfgReg_tb;
  logic        clk = 1'b0;
  logic        porN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic        eventActive = 1'b0;
  logic [15:0] rdData;
  logic [1:0]  hystSel;
  logic        shutdown, critLock, alarmLock, eventEnable, critOnly;
  logic        eventPolarity, intMode, clearEvent;

  int nChecks = 0;
  int nFails  = 0;
  logic [15:0] model = '0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  thermCfgReg u_dut (
    .clk(clk), .porN(porN), .wrEn(wrEn), .wrData(wrData), .eventActive(eventActive),
    .rdData(rdData), .hystSel(hystSel), .shutdown(shutdown), .critLock(critLock),
    .alarmLock(alarmLock), .eventEnable(eventEnable), .critOnly(critOnly),
    .eventPolarity(eventPolarity), .intMode(intMode), .clearEvent(clearEvent)
  );

  // Next stored image (bits 4, 5 and 15:11 always 0) from the requirements.
  function automatic logic [15:0] nextModel(logic [15:0] cur, logic [15:0] d);
    logic [15:0] n;
    logic locked;
    locked = cur[7] | cur[6];
    n = cur;
    if (!locked) begin
      n[10:9] = d[10:9]; n[3] = d[3]; n[1] = d[1]; n[0] = d[0]; n[8] = d[8];
    end else if (!d[8]) n[8] = 1'b0;
    if (d[7]) n[7] = 1'b1;
    if (d[6]) n[6] = 1'b1;
    if (!d[2]) n[2] = 1'b0;
    else if (!cur[6]) n[2] = 1'b1;
    return n;
  endfunction

  function automatic logic [15:0] outImage();
    return {5'b0, hystSel, shutdown, critLock, alarmLock, 2'b0,
            eventEnable, critOnly, eventPolarity, intMode};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic checkState(string req);
    chk(req, {16'b0, rdData}, {16'b0, model | (16'(eventActive) << 4)});
    chk(req, {16'b0, outImage()}, {16'b0, model});
  endtask

  task automatic doReset();
    @(negedge clk);
    porN = 1'b0; wrEn = 1'b0;
    repeat (2) @(negedge clk);
    porN = 1'b1;
    model = '0;
  endtask

  task automatic doWrite(logic [15:0] d, logic ev, string req);
    @(negedge clk);
    wrEn = 1'b1; wrData = d; eventActive = ev;
    @(negedge clk);
    wrEn = 1'b0;
    model = nextModel(model, d);
    checkState(req);
    chk("R8 pulse", {31'b0, clearEvent}, {31'b0, d[5]});
    if (d[5]) begin
      @(negedge clk);
      chk("R8 pulse end", {31'b0, clearEvent}, 32'd0);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    // R1 reset state
    doReset();
    @(negedge clk);
    chk("R1 reset", {16'b0, rdData}, 32'h0000);
    chk("R1 clearEvent", {31'b0, clearEvent}, 32'd0);
    eventActive = 1'b1;
    #1 chk("R9 status", {16'b0, rdData}, 32'h0010);
    // R3 R2 R6 R7 R9: unlocked write of everything except locks
    doWrite(16'hFF3F, 1'b1, "R3 R2 R9 unlocked all-ones");
    chk("R2 reserved", {16'b0, rdData}, 32'h071F);
    doWrite(16'h0000, 1'b0, "R3 R6 R7 clear");
    chk("R3 hyst 01", {16'b0, 14'b0, hystSel}, 32'd0);
    doWrite(16'h0200, 1'b0, "R3 hyst code 01");
    chk("R3 hystSel", {30'b0, hystSel}, 32'd1);
    doWrite(16'h0400, 1'b0, "R3 hyst code 10");
    doWrite(16'h0600, 1'b0, "R3 hyst code 11");
    // R10 lock set with same-write field changes
    doReset();
    doWrite(16'h0381, 1'b0, "R10 lock plus fields");
    chk("R10 image", {16'b0, rdData}, 32'h0381);
    doWrite(16'h0000, 1'b0, "R4 R5 R6 locked clear");
    chk("R6 shdn clears locked", {16'b0, rdData}, 32'h0281);
    doWrite(16'h0507, 1'b0, "R5 R6 R7 locked set");
    chk("R7 critOnly under critLock", {16'b0, rdData}, 32'h0285);
    doWrite(16'h0040, 1'b0, "R4 alarm lock");
    chk("R7 cleared, R4 both", {16'b0, rdData}, 32'h02C1);
    doWrite(16'h0004, 1'b0, "R7 blocked by alarm lock");
    chk("R7 image", {16'b0, rdData}, 32'h02C1);
    doReset();
    @(negedge clk);
    chk("R4 cleared by reset", {16'b0, rdData}, 32'h0000);
    // R8 pulse and read-as-zero, R2 reserved writes
    doWrite(16'h0020, 1'b0, "R8 clear write");
    chk("R8 reads zero", {16'b0, rdData}, 32'h0000);
    doWrite(16'hF830, 1'b0, "R2 R9 ignored bits");
    chk("R2 image", {16'b0, rdData}, 32'h0000);
    // Random phase
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] d;
      if (i % 250 == 0) doReset();
      d = 16'($urandom);
      if ($urandom % 12 != 0) d[7:6] = 2'b00;
      if ($urandom % 3 == 0) begin
        @(negedge clk);
        eventActive = 1'($urandom);
        #1 checkState("R5 R6 R7 idle hold");
      end else begin
        doWrite(d, 1'($urandom), "R3 R4 R5 R6 R7 R10 random");
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule